// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive path of an Ethernet MAC. It watches the byte stream of an incoming frame, starting at the byte marked as the start of the frame. It takes the first six bytes as the destination address and decides whether the frame is for this station. Four acceptance modes are each switched on or off by their own input, and the frame is accepted when any enabled mode matches. A global receive enable must also be high, or the frame is rejected.

The station address comes in as a 48-bit value split over two words. The low word holds address bits 31..0 and the high word holds bits 47..32. Byte k on the wire, counting from 0, is compared with station bits 8k+7..8k. So the first wire byte lines up with bits 7..0 of the low word, and the sixth lines up with bits 15..8 of the high word.

The verdict appears once the sixth address byte has been taken in. It is then held until the next start of frame, so the storage logic downstream can use it for the rest of the frame. A frame that ends before its address is complete gets a reject verdict.

Top module: `daf_rx_filter`

## Requirements
- R1: After reset, `dst_decided` and `dst_accept` are both 0.
- R2: With only unicast enabled, a frame is accepted when wire byte k (k = 0..5) equals station bits 8k+7..8k, where the low word supplies bits 31..0 and the high word supplies bits 47..32.
- R3: With only unicast enabled, a destination that differs from the station address in any single bit is rejected.
- R4: With only broadcast enabled, a destination of all ones is accepted and any other destination is rejected.
- R5: With only multicast enabled, a frame is accepted exactly when bit 0 of the first destination byte is 1.
- R6: With promiscuous enabled, every frame that carries a full six-byte address is accepted, whatever its destination.
- R7: Enabled modes combine by OR, and a frame is rejected when no mode is enabled.
- R8: When `rx_en` is low at the sixth address byte, the frame is rejected whatever the modes are.
- R9: The verdict is registered on the clock edge that takes in the sixth address byte. From that edge until the next start of frame, it stays unchanged by further bytes, by stray bytes outside a frame, and by changes to the modes, the enable or the station address.
- R10: A frame whose end marker arrives on one of its first five bytes ends with `dst_decided` = 1 and `dst_accept` = 0.
- R11: The edge that takes in a start-of-frame byte clears `dst_decided` and `dst_accept`, unless that same byte also ends the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable; when low, every frame is rejected |
| mode_prom | input | 1 | Promiscuous mode enable |
| mode_mcast | input | 1 | Multicast (group bit) mode enable |
| mode_bcast | input | 1 | Broadcast (all ones) mode enable |
| mode_ucast | input | 1 | Unicast (exact match) mode enable |
| sta_lo | input | 32 | Station address bits 31..0 |
| sta_hi | input | 16 | Station address bits 47..32 |
| rx_vld | input | 1 | A byte is present on `rx_byte` this cycle |
| rx_sof | input | 1 | The byte is the first of a frame |
| rx_eof | input | 1 | The byte is the last of a frame |
| rx_byte | input | 8 | Frame byte |
| dst_decided | output | 1 | A verdict for the current frame is available |
| dst_accept | output | 1 | The frame is accepted (valid while `dst_decided` is high) |

## Verification
The case hardest to reach from the ports is a frame whose address is wrong in only one bit of its last byte. Also hard to reach are frames whose end marker lands on the fifth byte, one short of a full address, or on the sixth byte, just enough. The stimulus sends unicast frames with single bits flipped in the first and last address bytes. It also sends frames of one, five and six bytes, and a frame with start and end on one byte. After an accept, the modes, the enable and the station address are all changed, stray bytes are sent outside any frame, and the held verdict is checked again before the next start of frame.

// File: rtl/daf_pkg.sv
package daf_pkg;
  localparam int BYTE_W     = 8;
  localparam int ADDR_BYTES = 6;
  localparam int LO_W       = 32;
  localparam int HI_W       = 16;
  localparam int ADDR_W     = LO_W + HI_W;

  typedef struct packed {
    logic prom;
    logic mcast;
    logic bcast;
    logic ucast;
  } mode_t;

  // Station byte that wire position idx is compared against.
  function automatic logic [BYTE_W-1:0] station_byte(input logic [ADDR_W-1:0] sta,
                                                     input int idx);
    return sta[idx*BYTE_W +: BYTE_W];
  endfunction

  // OR of the enabled acceptance modes.
  function automatic logic mode_hit(input mode_t m, input logic exact,
                                    input logic ones, input logic grp);
    return m.prom | (m.mcast & grp) | (m.bcast & ones) | (m.ucast & exact);
  endfunction
endpackage

// File: rtl/daf_byte_track.sv
module daf_byte_track
  import daf_pkg::*;
#(
  parameter int N_BYTES = ADDR_BYTES,
  parameter int DW      = BYTE_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        byte_vld,
  input  logic                        sof,
  input  logic                        eof,
  input  logic [DW-1:0]               byte_dat,
  input  logic [N_BYTES*DW-1:0]       sta,
  output logic                        frame_start,
  output logic                        hdr_done,
  output logic                        short_end,
  output logic                        exact_now,
  output logic                        ones_now,
  output logic                        grp_now
);
  localparam int CNT_W = $clog2(N_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N_BYTES - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(N_BYTES);

  logic [CNT_W-1:0] cnt_q;
  logic             in_frame_q;
  logic             exact_q, ones_q, grp_q;
  logic [CNT_W-1:0] pos;
  logic             take;
  logic [DW-1:0]    ref_byte;

  assign frame_start = byte_vld & sof;
  assign take        = byte_vld & (sof | (in_frame_q & (cnt_q < FULL)));
  assign pos         = (sof || cnt_q >= FULL) ? '0 : cnt_q;
  assign ref_byte    = sta[int'(pos)*DW +: DW];

  assign exact_now = (sof ? 1'b1 : exact_q) & (byte_dat == ref_byte);
  assign ones_now  = (sof ? 1'b1 : ones_q) & (&byte_dat);
  assign grp_now   = sof ? byte_dat[0] : grp_q;

  assign hdr_done  = take & (pos == LAST);
  assign short_end = take & eof & (pos < LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      in_frame_q <= 1'b0;
      exact_q    <= 1'b0;
      ones_q     <= 1'b0;
      grp_q      <= 1'b0;
    end else begin
      if (frame_start)          in_frame_q <= ~eof;
      else if (byte_vld && eof) in_frame_q <= 1'b0;
      if (take) begin
        cnt_q   <= pos + 1'b1;
        exact_q <= exact_now;
        ones_q  <= ones_now;
        grp_q   <= grp_now;
      end
    end
  end

  // R10: a byte ending a frame after its header leaves no open frame
  p_eof_closes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && eof) |=> !in_frame_q);
  // R9: header completion is followed by a saturated position
  p_hdr_saturates_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_done |=> (cnt_q == FULL));
endmodule

// File: rtl/daf_verdict.sv
module daf_verdict
  import daf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  frame_start,
  input  logic  hdr_done,
  input  logic  short_end,
  input  logic  rx_en,
  input  mode_t mode,
  input  logic  exact,
  input  logic  ones,
  input  logic  grp,
  output logic  decided,
  output logic  accept
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      decided <= 1'b0;
      accept  <= 1'b0;
    end else if (short_end) begin
      decided <= 1'b1;
      accept  <= 1'b0;
    end else if (hdr_done) begin
      decided <= 1'b1;
      accept  <= rx_en & mode_hit(mode, exact, ones, grp);
    end else if (frame_start) begin
      decided <= 1'b0;
      accept  <= 1'b0;
    end
  end

  p_short_reject_r10: assert property (@(posedge clk) disable iff (!rst_n)
    short_end |=> (decided && !accept));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (decided && !frame_start) |=> (decided && $stable(accept)));
  p_sof_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !short_end && !hdr_done) |=> (!decided && !accept));
  p_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_done && !rx_en) |=> !accept);
  p_nomode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_done && mode == '0) |=> !accept);
  p_prom_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_done && rx_en && mode.prom) |=> accept);
  p_ucast_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_done && rx_en && mode.ucast && exact) |=> accept);
endmodule

// File: rtl/daf_rx_filter.sv
module daf_rx_filter
  import daf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              mode_prom,
  input  logic              mode_mcast,
  input  logic              mode_bcast,
  input  logic              mode_ucast,
  input  logic [LO_W-1:0]   sta_lo,
  input  logic [HI_W-1:0]   sta_hi,
  input  logic              rx_vld,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              dst_decided,
  output logic              dst_accept
);
  mode_t             mode;
  logic [ADDR_W-1:0] sta;
  logic              frame_start, hdr_done, short_end;
  logic              exact_now, ones_now, grp_now;

  assign mode = '{prom: mode_prom, mcast: mode_mcast, bcast: mode_bcast, ucast: mode_ucast};
  assign sta  = {sta_hi, sta_lo};

  daf_byte_track #(.N_BYTES(ADDR_BYTES), .DW(BYTE_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_vld   (rx_vld),
    .sof        (rx_sof),
    .eof        (rx_eof),
    .byte_dat   (rx_byte),
    .sta        (sta),
    .frame_start(frame_start),
    .hdr_done   (hdr_done),
    .short_end  (short_end),
    .exact_now  (exact_now),
    .ones_now   (ones_now),
    .grp_now    (grp_now)
  );

  daf_verdict u_verdict (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .hdr_done   (hdr_done),
    .short_end  (short_end),
    .rx_en      (rx_en),
    .mode       (mode),
    .exact      (exact_now),
    .ones       (ones_now),
    .grp        (grp_now),
    .decided    (dst_decided),
    .accept     (dst_accept)
  );

  p_accept_needs_decided_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dst_accept |-> dst_decided);
  p_bcast_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_done && rx_en && mode_bcast && ones_now) |=> dst_accept);
  p_mcast_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_done && rx_en && mode_mcast && grp_now) |=> dst_accept);
endmodule

// File: tb/daf_rx_filter_tb.sv
module daf_rx_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b0;
  logic        mode_prom = 1'b0, mode_mcast = 1'b0, mode_bcast = 1'b0, mode_ucast = 1'b0;
  logic [31:0] sta_lo = 32'hA1B2_C3D4;
  logic [15:0] sta_hi = 16'h0E5F;
  logic        rx_vld = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic        dst_decided, dst_accept;

  int n_checks = 0;
  int n_fail   = 0;
  bit exp_q[$];
  string tag_q[$];
  logic [47:0] own;

  always #10 clk = ~clk;

  daf_rx_filter u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
    .mode_prom(mode_prom), .mode_mcast(mode_mcast),
    .mode_bcast(mode_bcast), .mode_ucast(mode_ucast),
    .sta_lo(sta_lo), .sta_hi(sta_hi),
    .rx_vld(rx_vld), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_byte(rx_byte),
    .dst_decided(dst_decided), .dst_accept(dst_accept)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Reference verdict, written from the requirements.
  function automatic bit ref_accept(input logic [47:0] dst, input int n);
    bit hit;
    if (n < 6 || !rx_en) return 1'b0;
    hit = 1'b0;
    if (mode_ucast && dst == {sta_hi, sta_lo}) hit = 1'b1;
    if (mode_bcast && dst == {48{1'b1}})       hit = 1'b1;
    if (mode_mcast && dst[0])                  hit = 1'b1;
    if (mode_prom)                             hit = 1'b1;
    return hit;
  endfunction

  task automatic set_modes(input bit p, input bit m, input bit b, input bit u);
    @(negedge clk);
    mode_prom = p; mode_mcast = m; mode_bcast = b; mode_ucast = u;
  endtask

  // Driver: sends a frame, wire byte k carries dst[8k+7:8k].
  task automatic send_frame(input logic [47:0] dst, input int n, input string tag);
    exp_q.push_back(ref_accept(dst, n));
    tag_q.push_back(tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k == 1)
        check(dst_decided == 1'b0 && dst_accept == 1'b0, "R11 sof clears verdict",
              int'(dst_decided), 0);
      rx_vld  = 1'b1;
      rx_sof  = (k == 0);
      rx_eof  = (k == n - 1);
      rx_byte = (k < 6) ? dst[8*k +: 8] : 8'(k * 37 + 5);
    end
    @(negedge clk);
    rx_vld = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_byte = 8'h00;
    @(negedge clk);
  endtask

  // Monitor: follows the input stream to find the decision byte.
  bit due = 1'b0;
  int mon_cnt = 6;
  bit mon_in = 1'b0;
  always @(posedge clk) begin
    int pos;
    bit d;
    d = 1'b0;
    if (rx_vld && (rx_sof || mon_in)) begin
      pos = rx_sof ? 0 : mon_cnt;
      if (pos == 5 || (rx_eof && pos < 5)) d = 1'b1;
      mon_cnt = (pos < 6) ? pos + 1 : 6;
      mon_in  = !rx_eof;
    end else if (rx_vld && rx_eof) begin
      mon_in = 1'b0;
    end
    due <= d;
  end

  always @(negedge clk) begin
    if (due) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "scoreboard underflow", 0, 1);
      end else begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(dst_decided == 1'b1 && dst_accept == e, t, int'(dst_accept), int'(e));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    own = {sta_hi, sta_lo};
    repeat (3) @(negedge clk);
    check(dst_decided == 1'b0 && dst_accept == 1'b0, "R1 reset state", int'(dst_decided), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(dst_decided == 1'b0 && dst_accept == 1'b0, "R1 after release", int'(dst_accept), 0);
    rx_en = 1'b1;

    set_modes(0, 0, 0, 1);
    send_frame(own, 20, "R2 unicast exact match");
    send_frame(own ^ 48'h0000_0000_0001, 12, "R3 unicast bit 0 flipped");
    send_frame(own ^ 48'h8000_0000_0000, 12, "R3 unicast bit 47 flipped");
    send_frame(own ^ 48'h0100_0000_0000, 8, "R3 unicast bit 40 flipped");
    send_frame({48{1'b1}}, 8, "R3 unicast rejects broadcast");

    set_modes(0, 0, 1, 0);
    send_frame({48{1'b1}}, 10, "R4 broadcast all ones");
    send_frame(48'h7FFF_FFFF_FFFF, 10, "R4 broadcast one zero bit");
    send_frame(own, 10, "R4 broadcast rejects own");

    set_modes(0, 1, 0, 0);
    send_frame(48'h1234_5678_9A01, 9, "R5 multicast group bit set");
    send_frame(48'h1234_5678_0100, 9, "R5 multicast bit 8 only");

    set_modes(1, 0, 0, 0);
    send_frame(48'h0000_0000_0000, 7, "R6 promiscuous zero dst");
    send_frame(48'h5A5A_3C3C_9696, 6, "R6 promiscuous six bytes");

    set_modes(0, 0, 0, 0);
    send_frame({48{1'b1}}, 8, "R7 no mode enabled");
    set_modes(0, 0, 1, 1);
    send_frame(own, 8, "R7 ucast|bcast own");
    send_frame({48{1'b1}}, 8, "R7 ucast|bcast all ones");
    send_frame(48'h2222_3333_4445, 8, "R7 ucast|bcast other");

    set_modes(1, 1, 1, 1);
    rx_en = 1'b0;
    send_frame(own, 8, "R8 receive disabled");
    rx_en = 1'b1;

    set_modes(1, 0, 0, 0);
    send_frame(48'h0102_0304_0506, 5, "R10 five-byte frame");
    send_frame(48'h0102_0304_0506, 1, "R10 sof and eof on one byte");
    send_frame(48'h0102_0304_0506, 6, "R10 six-byte frame accepted");

    // R9: hold after accept against changes and stray bytes
    send_frame(48'hCAFE_0000_BEEF, 9, "R9 frame before hold");
    set_modes(0, 0, 0, 0);
    rx_en = 1'b0;
    sta_lo = 32'h0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      rx_vld = 1'b1; rx_byte = 8'hFF; rx_eof = (k == 2);
    end
    @(negedge clk);
    rx_vld = 1'b0; rx_eof = 1'b0;
    repeat (5) @(negedge clk);
    check(dst_decided == 1'b1 && dst_accept == 1'b1, "R9 verdict held", int'(dst_accept), 1);
    rx_en = 1'b1;
    sta_lo = 32'hA1B2_C3D4;
    @(negedge clk);
    check(dst_accept == 1'b1, "R9 held after restore", int'(dst_accept), 1);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule